// File: doc/BRIEF.md
# Push-Button Trimmed Bias PWM

This block drives a pulse-width modulated pin at a fixed rate. A bias network outside the chip turns the pin into an adjustable voltage, for example a display contrast level. A 1 µs enable pulse advances a period counter that runs through 20 steps, which gives a 50 kHz waveform. The pin is high for the first *duty* steps of each period and low for the remaining steps.

Two active-low push buttons trim the duty setting. Both buttons pass through a two-flop synchroniser. They are then examined only on a slow poll strobe, which comes from dividing the 1 µs pulse down to 50 ms. At each poll a pressed up button raises the setting by one step and a pressed down button lowers it by one step. The up button wins when both are pressed. The setting stays within 3..19 and starts at 10 after reset. A new setting reaches the pin only at the next period boundary, so a period that has already started keeps its width.

Top module: `btn_pwm`

## Requirements
- R1: The period counter runs 0..PERIOD-1 (20 steps) and the pin waveform repeats every PERIOD enable pulses (40 clocks when the enable pulses every second clock).
- R2: Within a period the pin is high while the step count is below the active duty value and low otherwise. With duty d the pin is high for exactly d steps, starting at the period boundary.
- R3: After reset the duty output reads 10, the period counter is at step 0 and the pin is high.
- R4: The buttons are examined once per POLL_TICKS enable pulses (50000 by default, 50 ms). While a button is held, the duty changes by at most one step per poll and changes at no other time.
- R5: An up button (btn_up_n) that reads low at a poll raises the duty by 1. At 19 it stays at 19.
- R6: A down button (btn_dn_n) that reads low at a poll, while up is released, lowers the duty by 1. At 3 it stays at 3.
- R7: When both buttons are low at a poll, only the raise is applied. Pressing both at 19 leaves 19, and pressing both at 3 gives 4.
- R8: A duty change takes effect at the next period boundary. A period already in progress keeps the high width it started with.
- R9: With both buttons released, the duty never changes. The button inputs reach the poll logic through a two-flop synchroniser that resets to the released level.
- R10: Without enable pulses the period counter, the pin and the duty hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-clock enable pulse every 1 µs |
| btn_up_n | input | 1 | Raise button, active low, asynchronous |
| btn_dn_n | input | 1 | Lower button, active low, asynchronous |
| pwm_o | output | 1 | PWM output pin |
| duty_o | output | DUTY_W (5) | Current duty setting |

## Verification
The bench holds each button long enough to drive the setting into both clamps. A design with a wrong limit or a wrapping adder would read 20, 2 or a wrapped value there. It presses both buttons at each end of the range, which catches a design that gives the down button priority or cancels the two presses against each other. It measures every period's high width against the setting that was visible just before that period began, while a held button changes the setting in the middle of periods. A design that loads a new duty value immediately produces widths that match neither setting. It also times the gap between successive steps and stops the enable pulse mid-period, which catches a wrong poll divider and a counter that ignores its enable.

// File: rtl/btn_pwm_pkg.sv
package btn_pwm_pkg;

   // action chosen at a poll strobe; raise outranks lower
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // index of each button in the synchroniser array
   localparam int unsigned BTN_UP = 0;
   localparam int unsigned BTN_DN = 1;
   localparam int unsigned N_BTN  = 2;

endpackage

// File: rtl/btn_pwm_sync.sv
module btn_pwm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain_q;

   // released level (high) during reset so no spurious press is seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/btn_pwm_poll.sv
module btn_pwm_poll #(
   parameter int unsigned POLL_TICKS = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic poll
);

   localparam int unsigned DIV_W = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;

   generate
      if (POLL_TICKS == 1) begin : g_every_tick
         assign poll = tick;
      end else begin : g_divide
         logic [DIV_W-1:0] div_q;
         logic             last;

         assign last = (div_q == DIV_W'(POLL_TICKS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    div_q <= '0;
            else if (tick) div_q <= last ? '0 : div_q + 1'b1;
         end

         assign poll = tick && last;
      end
   endgenerate

endmodule

// File: rtl/btn_pwm_duty.sv
module btn_pwm_duty
   import btn_pwm_pkg::*;
#(
   parameter int unsigned DUTY_W    = 5,
   parameter int unsigned DUTY_INIT = 10,
   parameter int unsigned DUTY_MIN  = 3,
   parameter int unsigned DUTY_MAX  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll,
   input  logic              up_n,
   input  logic              dn_n,
   output logic [DUTY_W-1:0] duty
);

   step_e step;

   always_comb begin
      if (!up_n)      step = STEP_UP;
      else if (!dn_n) step = STEP_DOWN;
      else            step = STEP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty <= DUTY_W'(DUTY_INIT);
      end else if (poll) begin
         case (step)
            STEP_UP:   if (duty < DUTY_W'(DUTY_MAX)) duty <= duty + 1'b1;
            STEP_DOWN: if (duty > DUTY_W'(DUTY_MIN)) duty <= duty - 1'b1;
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/btn_pwm_wave.sv
module btn_pwm_wave #(
   parameter int unsigned PERIOD    = 20,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned DUTY_W    = 5,
   parameter int unsigned DUTY_INIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DUTY_W-1:0] duty_in,
   output logic              pwm,
   output logic [CNT_W-1:0]  cnt,
   output logic [DUTY_W-1:0] act
);

   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [DUTY_W-1:0] act_q, act_d;
   logic              pwm_q;
   logic              wrap;

   assign wrap = (cnt_q == CNT_W'(PERIOD - 1));

   // the compare value is taken over only as a new period begins
   always_comb begin
      cnt_d = cnt_q;
      act_d = act_q;
      if (tick) begin
         if (wrap) begin
            cnt_d = '0;
            act_d = duty_in;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= DUTY_W'(DUTY_INIT);
         pwm_q <= (DUTY_INIT > 0);
      end else begin
         cnt_q <= cnt_d;
         act_q <= act_d;
         pwm_q <= (DUTY_W'(cnt_d) < act_d);
      end
   end

   assign pwm = pwm_q;
   assign cnt = cnt_q;
   assign act = act_q;

endmodule

// File: rtl/btn_pwm.sv
module btn_pwm
   import btn_pwm_pkg::*;
#(
   parameter int unsigned PERIOD      = 20,
   parameter int unsigned DUTY_INIT   = 10,
   parameter int unsigned DUTY_MIN    = 3,
   parameter int unsigned DUTY_MAX    = 19,
   parameter int unsigned POLL_TICKS  = 50000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DUTY_W      = $clog2(PERIOD + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1us,
   input  logic              btn_up_n,
   input  logic              btn_dn_n,
   output logic              pwm_o,
   output logic [DUTY_W-1:0] duty_o
);

   localparam int unsigned CNT_W = $clog2(PERIOD);

   // elaboration-time parameter checks
   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("btn_pwm: PERIOD must be at least 2");
      end
      if (DUTY_MIN > DUTY_MAX || DUTY_MAX > PERIOD) begin : g_bad_limits
         $error("btn_pwm: need DUTY_MIN <= DUTY_MAX <= PERIOD");
      end
      if (DUTY_INIT < DUTY_MIN || DUTY_INIT > DUTY_MAX) begin : g_bad_init
         $error("btn_pwm: DUTY_INIT outside the clamp window");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("btn_pwm: SYNC_STAGES must be at least 2");
      end
      if (POLL_TICKS < 1) begin : g_bad_poll
         $error("btn_pwm: POLL_TICKS must be at least 1");
      end
      if (DUTY_W < $clog2(PERIOD + 1) || DUTY_W < CNT_W) begin : g_bad_width
         $error("btn_pwm: DUTY_W too narrow for PERIOD");
      end
   endgenerate

   logic [N_BTN-1:0]  btn_raw_n;
   logic [N_BTN-1:0]  btn_s_n;
   logic              poll_p;
   logic [DUTY_W-1:0] duty_set;
   logic [CNT_W-1:0]  cnt_q;
   logic [DUTY_W-1:0] act_duty;

   assign btn_raw_n[BTN_UP] = btn_up_n;
   assign btn_raw_n[BTN_DN] = btn_dn_n;

   for (genvar b = 0; b < N_BTN; b++) begin : g_sync
      btn_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_in  (btn_raw_n[b]),
         .q_out (btn_s_n[b])
      );
   end

   btn_pwm_poll #(.POLL_TICKS(POLL_TICKS)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_1us),
      .poll  (poll_p)
   );

   btn_pwm_duty #(
      .DUTY_W    (DUTY_W),
      .DUTY_INIT (DUTY_INIT),
      .DUTY_MIN  (DUTY_MIN),
      .DUTY_MAX  (DUTY_MAX)
   ) u_duty (
      .clk   (clk),
      .rst_n (rst_n),
      .poll  (poll_p),
      .up_n  (btn_s_n[BTN_UP]),
      .dn_n  (btn_s_n[BTN_DN]),
      .duty  (duty_set)
   );

   btn_pwm_wave #(
      .PERIOD    (PERIOD),
      .CNT_W     (CNT_W),
      .DUTY_W    (DUTY_W),
      .DUTY_INIT (DUTY_INIT)
   ) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1us),
      .duty_in (duty_set),
      .pwm     (pwm_o),
      .cnt     (cnt_q),
      .act     (act_duty)
   );

   assign duty_o = duty_set;

endmodule

// File: rtl/btn_pwm_chk.sv
module btn_pwm_chk #(
   parameter int unsigned PERIOD   = 20,
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned DUTY_W   = 5,
   parameter int unsigned DUTY_MIN = 3,
   parameter int unsigned DUTY_MAX = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              poll,
   input logic              up_s_n,
   input logic              dn_s_n,
   input logic              pwm_o,
   input logic [DUTY_W-1:0] duty_o,
   input logic [DUTY_W-1:0] act,
   input logic [CNT_W-1:0]  cnt
);

   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(PERIOD));

   a_r2_pin_level: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_o == (DUTY_W'(cnt) < act));

   a_r4_change_on_poll: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(duty_o) |-> $past(poll));

   a_r5_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
      duty_o >= DUTY_W'(DUTY_MIN) && duty_o <= DUTY_W'(DUTY_MAX));

   a_r7_up_wins: assert property (@(posedge clk) disable iff (!rst_n)
      poll && !up_s_n && duty_o < DUTY_W'(DUTY_MAX)
      |=> duty_o == DUTY_W'($past(duty_o) + 1'b1));

   a_r6_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      poll && up_s_n && !dn_s_n && duty_o > DUTY_W'(DUTY_MIN)
      |=> duty_o == DUTY_W'($past(duty_o) - 1'b1));

   a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act) |-> cnt == '0);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      poll && up_s_n && dn_s_n |=> $stable(duty_o));

   a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt) && $stable(pwm_o));

endmodule

bind btn_pwm btn_pwm_chk #(
   .PERIOD   (PERIOD),
   .CNT_W    (CNT_W),
   .DUTY_W   (DUTY_W),
   .DUTY_MIN (DUTY_MIN),
   .DUTY_MAX (DUTY_MAX)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick_1us),
   .poll   (poll_p),
   .up_s_n (btn_s_n[0]),
   .dn_s_n (btn_s_n[1]),
   .pwm_o  (pwm_o),
   .duty_o (duty_o),
   .act    (act_duty),
   .cnt    (cnt_q)
);

// File: tb/sim_btn_pwm.sv
module sim_btn_pwm;

   localparam int unsigned POLL_T   = 8;
   localparam int unsigned PER_CLK  = 40;   // 20 steps x 2 clocks
   localparam int unsigned POLL_CLK = 16;   // 8 ticks x 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_en = 1'b1;
   logic       up_n = 1'b1;
   logic       dn_n = 1'b1;
   logic       pwm;
   logic [4:0] duty;

   int vecs = 0;
   int fails = 0;
   int cyc = 0;

   btn_pwm #(.POLL_TICKS(POLL_T)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1us (tick),
      .btn_up_n (up_n),
      .btn_dn_n (dn_n),
      .pwm_o    (pwm),
      .duty_o   (duty)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      tick <= tick_en ? ~tick : 1'b0;
   end

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // wait at negedges until duty differs from start; returns cycle stamp
   task automatic wait_change(input string req, output int stamp);
      int start = duty;
      stamp = -1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (duty != start) begin
            stamp = cyc;
            break;
         end
      end
      if (stamp < 0) chk({req, " step seen"}, 0, 1);
   endtask

   // measure n full periods: width vs duty seen before boundary, length 40
   task automatic measure(input string req, input int n);
      int prev_duty = duty;
      int prev_pwm  = pwm;
      int done = 0;
      int hi = 0, len = 0, exp_d = 0;
      bit armed = 0;
      while (done < n) begin
         @(negedge clk);
         if (pwm && !prev_pwm) begin
            if (armed) begin
               chk({req, " high width"}, hi, 2 * exp_d);
               chk({req, " period R1"}, len, PER_CLK);
               done++;
            end
            armed = 1;
            exp_d = prev_duty;
            hi = 0;
            len = 0;
         end
         if (armed) begin
            len++;
            if (pwm) hi++;
         end
         prev_duty = duty;
         prev_pwm  = pwm;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R3 duty after reset", duty, 10);
      chk("R3 pin after reset", pwm, 1);
   endtask

   task automatic t_idle;
      idle(6 * POLL_CLK);
      chk("R9 released buttons keep duty", duty, 10);
   endtask

   task automatic t_shape(input string req, input int exp);
      chk({req, " setting"}, duty, exp);
      measure(req, 2);
   endtask

   task automatic t_step_up;
      int s;
      up_n = 1'b0;
      wait_change("R5", s);
      up_n = 1'b1;
      chk("R5 single step up", duty, 11);
      idle(5 * POLL_CLK);
      chk("R9 hold after release", duty, 11);
   endtask

   task automatic t_interval;
      int s1, s2;
      up_n = 1'b0;
      wait_change("R4", s1);
      wait_change("R4", s2);
      up_n = 1'b1;
      chk("R4 clocks between steps", s2 - s1, POLL_CLK);
      chk("R4 one step per poll", duty, 13);
   endtask

   task automatic t_sat_up;
      up_n = 1'b0;
      idle(25 * POLL_CLK);
      up_n = 1'b1;
      idle(4);
      chk("R5 clamp at 19", duty, 19);
   endtask

   task automatic t_both_max;
      up_n = 1'b0;
      dn_n = 1'b0;
      idle(6 * POLL_CLK);
      up_n = 1'b1;
      dn_n = 1'b1;
      idle(4);
      chk("R7 both pressed at 19", duty, 19);
   endtask

   task automatic t_sweep;
      fork
         begin
            dn_n = 1'b0;
            idle(4);
         end
         measure("R8 sweep", 5);
      join
      dn_n = 1'b1;
      idle(4);
   endtask

   task automatic t_sat_down;
      dn_n = 1'b0;
      idle(25 * POLL_CLK);
      dn_n = 1'b1;
      idle(4);
      chk("R6 clamp at 3", duty, 3);
   endtask

   task automatic t_both_min;
      int s;
      up_n = 1'b0;
      dn_n = 1'b0;
      wait_change("R7", s);
      up_n = 1'b1;
      dn_n = 1'b1;
      chk("R7 both pressed at 3 raises", duty, 4);
   endtask

   task automatic t_no_tick;
      int p0, d0, bad;
      idle(7);
      tick_en = 1'b0;
      idle(3);
      p0 = pwm;
      d0 = duty;
      bad = 0;
      up_n = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (pwm != p0) bad++;
      end
      chk("R10 pin frozen without tick", bad, 0);
      chk("R10 duty frozen without tick", duty, d0);
      up_n = 1'b1;
      idle(4);
      tick_en = 1'b1;
      measure("R10 resume", 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_idle();
      t_shape("R2 duty 10", 10);
      t_step_up();
      t_interval();
      t_sat_up();
      t_shape("R2 duty 19", 19);
      t_both_max();
      t_sweep();
      t_sat_down();
      t_shape("R2 duty 3", 3);
      t_both_min();
      t_no_tick();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule